// File: doc/BRIEF.md
# Banked GPIO Port with Peripheral Override

An 8-bit general-purpose I/O port for a small controller. It holds an output latch and a direction register, one direction bit per pin. Both registers sit behind a single bus address. A map-select input picks which one a bus access reaches: when it is 1 the access goes to the direction register, and when it is 0 it goes to the data latch. The CPU may write the latch at any time. Each pin drives its latch value only while its direction bit marks it as an output.

On-chip peripherals can take over pins, one at a time. Such peripherals are a timer compare, serial data and clock outputs, and PWM channels. An asserted peripheral enable forces its pin to an output and drives the peripheral's value onto it. The stored direction bit does not change, and writes to the latch no longer reach that pin.

One pin position, `TCMP_BIT` (3 by default), belongs to the timer compare. It always reads back as the pin level. Whenever it is driven, it carries the timer compare value and never the latch. Pin inputs pass through a synchronizer before they reach the read mux.

Top module: `gpio_bank_port`

## Requirements
- R1: After reset the direction register reads 0x00 (with `map_sel_i`=1), and with no peripheral enabled every `pad_oe_o` bit is 0.
- R2: With `map_sel_i`=0, the read-data bit of a pin whose direction bit is 1 equals its latch bit. For a pin whose direction bit is 0, it equals the synchronized pin level.
- R3: With `map_sel_i`=0, read-data bit `TCMP_BIT` always equals the synchronized pin level, whatever its direction bit holds.
- R4: A write (`acc_en_i`=1, `wr_en_i`=1) with `map_sel_i`=0 stores `wdata_i` into the latch at the clock edge. A pin that is an output with no peripheral enabled then drives its latch bit on `pad_out_o`.
- R5: While `periph_en_i[i]`=1, `pad_out_o[i]` equals `periph_val_i[i]`, and latch writes do not change the pin.
- R6: Enabling or disabling a peripheral leaves the stored direction register unchanged, as seen through a read with `map_sel_i`=1.
- R7: Whenever `pad_oe_o[TCMP_BIT]`=1, `pad_out_o[TCMP_BIT]` equals `periph_val_i[TCMP_BIT]`, the timer compare output. This holds when the pin is enabled by its direction bit or by its peripheral enable.
- R8: A write with `map_sel_i`=1 loads `wdata_i` into the direction register and leaves the latch unchanged. A write with `map_sel_i`=0 leaves the direction register unchanged.
- R9: `pad_oe_o[i]` is 1 exactly when direction bit i is 1 or `periph_en_i[i]` is 1. Direction encoding: 1 means output, 0 means input.
- R10: A change on `pad_in_i` appears in read data `SYNC_STAGES` (2) rising clock edges later, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_en_i | input | 1 | Bus access strobe for the port address |
| wr_en_i | input | 1 | Write qualifier for the access |
| map_sel_i | input | 1 | Map select: 1 reaches the direction register, 0 reaches the data latch |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| periph_en_i | input | 8 | Per-pin peripheral output enable |
| periph_val_i | input | 8 | Per-pin peripheral output value; bit 3 is the timer compare |
| pad_in_i | input | 8 | Pad input levels |
| pad_oe_o | output | 8 | Pad output enables |
| pad_out_o | output | 8 | Pad output values |

## Verification
The bench targets the timer-compare pin. A design that decodes it like the other pins would return the latch on reads while it is an output, or drive the latch onto the pin. Both show up in `rdata_o` and `pad_out_o`. Latch writes are made while peripherals own pins. A design that lets the latch reach an owned pin, or that clears direction bits on enable, fails the per-cycle pad comparison and the direction read-back. Input steps are timed against the two-stage synchronizer, and map-select toggles between writes, so an off-by-one latency or a write that reaches the wrong register shows up in the read data within a cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic {
    RD_SRC_PIN   = 1'b0,
    RD_SRC_LATCH = 1'b1
  } rd_src_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_port_pkg::*;
#(
  parameter bit IS_TCMP = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_we_i,
  input  logic dat_we_i,
  input  logic wbit_i,
  input  logic pin_sync_i,
  input  logic pen_i,
  input  logic pval_i,
  output logic dir_o,
  output logic oe_o,
  output logic out_o,
  output logic rd_o
);
  logic    dir_q;
  rd_src_e rd_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= 1'b0;
    else if (dir_we_i) dir_q <= wbit_i;
  end

  assign dir_o = dir_q;
  assign oe_o  = dir_q | pen_i;

  if (IS_TCMP) begin : g_tcmp
    // timer compare owns the pin value; no latch stored here
    logic tcmp_unused;
    assign tcmp_unused = dat_we_i ^ wbit_i;
    assign rd_src = RD_SRC_PIN;
    assign out_o  = pval_i;
    assign rd_o   = pin_sync_i;
  end else begin : g_gen
    logic lat_q;
    // latch deliberately has no reset value
    always_ff @(posedge clk_i) begin
      if (dat_we_i) lat_q <= wbit_i;
    end
    assign rd_src = dir_q ? RD_SRC_LATCH : RD_SRC_PIN;
    assign out_o  = pen_i ? pval_i : lat_q;
    assign rd_o   = (rd_src == RD_SRC_LATCH) ? lat_q : pin_sync_i;
  end
endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port #(
  parameter int WIDTH       = 8,
  parameter int TCMP_BIT    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_en_i,
  input  logic             wr_en_i,
  input  logic             map_sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] periph_en_i,
  input  logic [WIDTH-1:0] periph_val_i,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_out_o
);
  localparam int TB = TCMP_BIT;

  logic             wr_hit, dir_we, dat_we;
  logic [WIDTH-1:0] pin_sync, dir_vec, rd_vec;

  assign wr_hit = acc_en_i & wr_en_i;
  assign dir_we = wr_hit & map_sel_i;
  assign dat_we = wr_hit & ~map_sel_i;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pin_sync)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    gpio_pin_slice #(.IS_TCMP(i == TB)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .dir_we_i  (dir_we),
      .dat_we_i  (dat_we),
      .wbit_i    (wdata_i[i]),
      .pin_sync_i(pin_sync[i]),
      .pen_i     (periph_en_i[i]),
      .pval_i    (periph_val_i[i]),
      .dir_o     (dir_vec[i]),
      .oe_o      (pad_oe_o[i]),
      .out_o     (pad_out_o[i]),
      .rd_o      (rd_vec[i])
    );

    AST_OWNED_PIN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (periph_en_i[i] && $past(periph_en_i[i]) && $stable(periph_val_i[i]))
        |-> $stable(pad_out_o[i])) else $error("owned pin moved"); // R5
  end

  assign rdata_o = map_sel_i ? dir_vec : rd_vec;

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_DIR: assert (dir_vec == '0 && pad_oe_o == periph_en_i)
      else $error("reset state"); // R1
  end

  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_en_i && wr_en_i && map_sel_i) |=> $stable(dir_vec))
    else $error("dir changed"); // R8
  AST_DIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && wr_en_i && map_sel_i) |=> dir_vec == $past(wdata_i))
    else $error("dir load"); // R8
  AST_TCMP_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o[TB] |-> pad_out_o[TB] == periph_val_i[TB])
    else $error("tcmp value"); // R7
  AST_TCMP_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_sel_i |-> rdata_o[TB] == pin_sync[TB])
    else $error("tcmp read"); // R3
  AST_DIR_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~periph_en_i) == (dir_vec & ~periph_en_i))
    else $error("oe vs dir"); // R9
endmodule

// File: tb/gpio_bank_port_bench.sv
module gpio_bank_port_bench;
  localparam int W = 8;
  localparam int T = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc = 1'b0, wr = 1'b0, msel = 1'b0;
  logic [W-1:0] wdata = '0, pen = '0, pval = '0, pin = '0;
  logic [W-1:0] rdata, oe, pout;

  always #4 clk = ~clk;

  gpio_bank_port u_gpio_bank_port (
    .clk_i(clk), .rst_ni(rst_n), .acc_en_i(acc), .wr_en_i(wr), .map_sel_i(msel),
    .wdata_i(wdata), .rdata_o(rdata), .periph_en_i(pen), .periph_val_i(pval),
    .pad_in_i(pin), .pad_oe_o(oe), .pad_out_o(pout)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] m_dir = '0, m_lat = '0, m_known = '0;
  logic [W-1:0] sq[$];

  function automatic logic [W-1:0] m_sync();
    return (sq.size() >= 2) ? sq[sq.size()-2] : '0;
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act,
                     logic [W-1:0] exp, logic [W-1:0] mask);
    checks++;
    if (((act ^ exp) & mask) != '0) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (mask %h)", tag, what, act, exp, mask);
    end
  endtask

  task automatic compare(string tag);
    logic [W-1:0] e_oe, e_out, m_out, e_rd, m_rd, sy;
    sy = m_sync();
    e_oe = m_dir | pen;
    m_out = '0;
    for (int i = 0; i < W; i++) begin
      if (i == T || pen[i]) begin e_out[i] = pval[i]; m_out[i] = e_oe[i]; end
      else begin e_out[i] = m_lat[i]; m_out[i] = e_oe[i] & m_known[i]; end
    end
    if (msel) begin e_rd = m_dir; m_rd = '1; end
    else begin
      for (int i = 0; i < W; i++) begin
        if (m_dir[i] && i != T) begin e_rd[i] = m_lat[i]; m_rd[i] = m_known[i]; end
        else begin e_rd[i] = sy[i]; m_rd[i] = 1'b1; end
      end
    end
    chk(tag, "pad_oe", oe, e_oe, '1);
    chk(tag, "pad_out", pout, e_out, m_out);
    chk(tag, "rdata", rdata, e_rd, m_rd);
  endtask

  // called at a negedge with inputs already set
  task automatic cyc(string tag);
    #1;
    compare(tag);
    @(posedge clk);
    if (acc && wr && msel) m_dir = wdata;
    if (acc && wr && !msel) begin m_lat = wdata; m_known = '1; end
    sq.push_back(pin);
    if (sq.size() > 2) void'(sq.pop_front());
    @(negedge clk);
  endtask

  task automatic wr_reg(string tag, logic sel, logic [W-1:0] d);
    acc = 1; wr = 1; msel = sel; wdata = d;
    cyc(tag);
    acc = 0; wr = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    msel = 1; cyc("R1"); cyc("R1");
    chk("R1", "dir reset", rdata, '0, '1);
    chk("R1", "oe reset", oe, '0, '1);
    // R4: latch write, then R8: direction write keeps latch
    wr_reg("R4", 1'b0, 8'hA5);
    wr_reg("R8", 1'b1, 8'hF0);
    msel = 1; cyc("R8");
    chk("R8", "dir load", rdata, 8'hF0, '1);
    msel = 0; cyc("R4");
    chk("R4", "pad_out latch", pout & 8'hF0, 8'hA0, '1);
    wr_reg("R8", 1'b0, 8'h3C);
    msel = 1; cyc("R8");
    chk("R8", "dir kept on data write", rdata, 8'hF0, '1);
    // R2 and R10: mixed directions, input steps
    msel = 0;
    pin = 8'h0F; cyc("R10");
    chk("R10", "one edge early", rdata & 8'h0F, 8'h00, '1);
    cyc("R10");
    chk("R10", "after two edges", rdata & 8'h0F, 8'h0F, '1);
    pin = 8'h05; cyc("R2"); cyc("R2"); cyc("R2");
    chk("R2", "mixed read", rdata, 8'h35, '1);
    // R3: all outputs, bit 3 still reads pin
    wr_reg("R3", 1'b1, 8'hFF);
    wr_reg("R3", 1'b0, 8'h00);
    msel = 0; pin = 8'h08; cyc("R3"); cyc("R3"); cyc("R3");
    chk("R3", "tcmp bit reads pin", rdata, 8'h08, '1);
    // R7: timer compare drives pin 3
    pval = 8'h08; cyc("R7");
    chk("R7", "tcmp high", pout[T], 1'b1, 1'b1);
    pval = 8'h00; cyc("R7");
    chk("R7", "tcmp low", pout[T], 1'b0, 1'b1);
    // R5, R6, R9: peripheral ownership
    wr_reg("R9", 1'b1, 8'h00);
    pen = 8'h81; pval = 8'h01; msel = 0; cyc("R9");
    chk("R9", "oe from enables", oe, 8'h81, '1);
    wr_reg("R5", 1'b0, 8'hFE);
    chk("R5", "owned pins ignore latch", pout & 8'h81, 8'h01, '1);
    msel = 1; cyc("R6");
    chk("R6", "dir untouched by enable", rdata, 8'h00, '1);
    pen = 8'h00; cyc("R6");
    chk("R6", "dir after disable", rdata, 8'h00, '1);
    chk("R9", "oe released", oe, 8'h00, '1);
    // random traffic, model compared every cycle
    for (int k = 0; k < 400; k++) begin
      acc = $urandom_range(0, 3) == 0; wr = 1; msel = $urandom_range(0, 1);
      wdata = $urandom; pen = $urandom & $urandom; pval = $urandom; pin = $urandom;
      cyc("R2/R5/R9");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule